// File: doc/BRIEF.md
# Masked Pipelined Vector Execution Unit

This block is the arithmetic unit that a vector core uses for one vector instruction at a time. After the unit accepts an instruction, it steps through the elements of the two source vectors, one element per clock cycle. Each element passes through a four-stage pipeline, so up to four elements are in flight at once, and no hazard check is made between them. The number of elements taken comes from a length value that is captured when the instruction starts. Every element is predicated by a bit of the unit's own mask register.

The arithmetic operations are add, subtract and an unsigned halve (a logical shift right by one). An element whose mask bit is clear keeps its previous destination value. The test operation writes no result. It rewrites the mask register instead: each tested bit becomes 1 where the source element is zero. The destination vector and the mask are held inside the unit and are visible on its outputs. While the unit is idle, the mask can be loaded from outside. The sources are supplied as whole flat vectors and must be held stable until `done` is seen.

Top module: `vec_exec_unit`

## Requirements
- R1: After reset the destination vector is all zeros, the mask is all ones, and `busy` and `done` are low.
- R2: A start accepted with an effective length L of 1 or more processes elements 0 to L-1 in consecutive cycles through a 4-stage pipeline. `done` is high for exactly one cycle, L+4 cycles after the accepting edge. The results are visible on `dst_vec`/`mask_vec` in that same cycle, and `busy` is low again.
- R3: A length above N is clamped to N. Elements at positions L and above are never written.
- R4: A length of zero writes nothing and raises `done` for one cycle, one cycle after the accepting edge.
- R5: Opcode 0 computes a+b modulo 2^W. Opcode 1 computes a-b modulo 2^W. Opcode 2 computes a shifted right logically by one bit; b is unused.
- R6: For opcodes 0 to 2, element i is written only when mask bit i is 1. Otherwise it keeps its previous value. Element i occupies bits [i*W +: W] of the vector ports, and mask bit i is bit i.
- R7: Opcode 3 (test) ignores the current mask. For each i < L it sets mask bit i to 1 if element i of `a_vec` is zero, and to 0 otherwise. Mask bits at L and above and the whole destination vector are left unchanged.
- R8: `start` and `mask_load` are ignored while `busy` is high.
- R9: `mask_load` while idle replaces the mask with `mask_wdata` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 2 | 0 add, 1 subtract, 2 halve, 3 test-zero |
| vlen | input | $clog2(N+1) | Element count for the instruction |
| a_vec | input | N*W | First source vector, flat |
| b_vec | input | N*W | Second source vector, flat |
| mask_load | input | 1 | Load the mask register (idle only) |
| mask_wdata | input | N | Value for the mask load |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| dst_vec | output | N*W | Destination vector register, flat |
| mask_vec | output | N | Mask register |

## Verification
The hardest situation to reach from the ports is a `start` or `mask_load` that arrives while elements are still draining through the pipeline. Done correctly, such a request must change neither the instruction in flight nor the mask that predicates it. The bench reaches this state by injecting a conflicting start and mask load two cycles into selected instructions. It then compares the results with a model that ignores the injected request. Clamped lengths, zero length, a fully cleared mask and a test that follows arithmetic on the same mask are driven as directed cases, between seeded random instructions.

// File: rtl/vec_pkg.sv
// Shared definitions for the vector execution unit.
package vec_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_HALF = 2'd2,
        OP_TSTZ = 2'd3
    } vop_e;
endpackage

// File: rtl/vec_issue_ctrl.sv
// Issue controller: accepts an instruction when idle, clamps its length,
// issues one element index per cycle and raises done after the last
// element's writeback. Assumes the writeback pipeline reports its last element.
module vec_issue_ctrl
    import vec_pkg::*;
#(
    parameter int N     = 8,
    parameter int CNT_W = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  vop_e             op_in,
    input  logic [CNT_W-1:0] vlen_in,
    input  logic             wb_last,
    output logic             busy,
    output logic             done,
    output vop_e             op_q,
    output logic             issue_valid,
    output logic [IDX_W-1:0] issue_idx,
    output logic             issue_last
);
    logic [CNT_W-1:0] vlen_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] vlen_eff;

    // Clamp the requested length to the register capacity.
    always_comb vlen_eff = (vlen_in > CNT_W'(N)) ? CNT_W'(N) : vlen_in;

    // Issue one element per cycle while elements remain.
    always_comb begin
        issue_valid = busy && (cnt < vlen_q);
        issue_idx   = cnt[IDX_W-1:0];
        issue_last  = (cnt == vlen_q - CNT_W'(1));
    end

    // Instruction acceptance, element counting and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            vlen_q <= '0;
            op_q   <= OP_ADD;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                op_q   <= op_in;
                vlen_q <= vlen_eff;
                cnt    <= '0;
                if (vlen_eff == '0) done <= 1'b1;
                else                busy <= 1'b1;
            end else if (busy) begin
                if (issue_valid) cnt <= cnt + CNT_W'(1);
                if (wb_last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R8
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !wb_last |=> $stable(op_q));
    // R2
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wb_last |=> done && !busy);
endmodule

// File: rtl/vec_alu.sv
// Element operation: add, subtract, unsigned halve, or zero test.
// Combinational; the test result is placed in bit 0.
module vec_alu
    import vec_pkg::*;
#(
    parameter int W = 16
) (
    input  vop_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    // Select the element result for the opcode.
    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_HALF: res = a >> 1;
            default: res = {{(W-1){1'b0}}, (a == '0)};
        endcase
    end
endmodule

// File: rtl/vec_lane_pipe.sv
// Element pipeline of DEPTH stages: stage 1 fetches the operands, stage 2
// holds the ALU result, and later stages carry it forward. Each stage carries
// a valid bit, the element index and a last flag. Assumes DEPTH >= 2.
module vec_lane_pipe
    import vec_pkg::*;
#(
    parameter int N     = 8,
    parameter int W     = 16,
    parameter int IDX_W = 3,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vop_e             op,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    input  logic             in_last,
    input  logic [N*W-1:0]   a_vec,
    input  logic [N*W-1:0]   b_vec,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx,
    output logic             wb_last,
    output logic [W-1:0]     wb_res
);
    logic             s1_valid, s1_last;
    logic [IDX_W-1:0] s1_idx;
    logic [W-1:0]     s1_a, s1_b, alu_res;

    logic             st_valid [2:DEPTH];
    logic             st_last  [2:DEPTH];
    logic [IDX_W-1:0] st_idx   [2:DEPTH];
    logic [W-1:0]     st_res   [2:DEPTH];

    // Stage 1: read the selected element of each source vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s1_idx   <= '0;
            s1_a     <= '0;
            s1_b     <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_last  <= in_valid && in_last;
            s1_idx   <= in_idx;
            s1_a     <= a_vec[in_idx*W +: W];
            s1_b     <= b_vec[in_idx*W +: W];
        end
    end

    vec_alu #(.W(W)) u_alu (
        .op  (op),
        .a   (s1_a),
        .b   (s1_b),
        .res (alu_res)
    );

    // Stage 2: capture the ALU result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid[2] <= 1'b0;
            st_last[2]  <= 1'b0;
            st_idx[2]   <= '0;
            st_res[2]   <= '0;
        end else begin
            st_valid[2] <= s1_valid;
            st_last[2]  <= s1_last;
            st_idx[2]   <= s1_idx;
            st_res[2]   <= alu_res;
        end
    end

    for (genvar k = 3; k <= DEPTH; k++) begin : g_carry
        // Carry stage: forward the previous stage unchanged.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_valid[k] <= 1'b0;
                st_last[k]  <= 1'b0;
                st_idx[k]   <= '0;
                st_res[k]   <= '0;
            end else begin
                st_valid[k] <= st_valid[k-1];
                st_last[k]  <= st_last[k-1];
                st_idx[k]   <= st_idx[k-1];
                st_res[k]   <= st_res[k-1];
            end
        end
    end

    assign wb_valid = st_valid[DEPTH];
    assign wb_last  = st_last[DEPTH];
    assign wb_idx   = st_idx[DEPTH];
    assign wb_res   = st_res[DEPTH];

    // R2
    stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> st_valid[2] && (st_idx[2] == $past(s1_idx)));
    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && s1_valid && !s1_last |-> in_idx == s1_idx + IDX_W'(1));
    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> int'(wb_idx) < N);
endmodule

// File: rtl/vec_wb_regs.sv
// Destination vector and mask registers. Arithmetic writebacks are
// predicated by the mask, and test writebacks rewrite one mask bit each.
// External mask loads are honoured only while the unit is idle.
module vec_wb_regs #(
    parameter int N     = 8,
    parameter int W     = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             is_test,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [W-1:0]     wb_res,
    input  logic             mask_load,
    input  logic [N-1:0]     mask_wdata,
    output logic [N*W-1:0]   dst_vec,
    output logic [N-1:0]     mask_vec
);
    logic [W-1:0] dst_q [N];
    logic [N-1:0] mask_q;

    // Mask register: idle load or test writeback.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mask_q <= '1;
        else if (mask_load && !busy) mask_q <= mask_wdata;
        else if (wb_valid && is_test) mask_q[wb_idx] <= wb_res[0];
    end

    // Destination register: masked arithmetic writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) dst_q[i] <= '0;
        end else if (wb_valid && !is_test && mask_q[wb_idx]) begin
            dst_q[wb_idx] <= wb_res;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_flat
        assign dst_vec[i*W +: W] = dst_q[i];
    end
    assign mask_vec = mask_q;

    // R6
    dst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && !is_test) |=> $stable(dst_vec));
    // R8
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && is_test) && !(mask_load && !busy) |=> $stable(mask_vec));
    // R9
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_load && !busy |=> mask_vec == $past(mask_wdata));
endmodule

// File: rtl/vec_exec_unit.sv
// Top of the masked pipelined vector execution unit. Connects the issue
// controller, the element pipeline and the writeback registers. Assumes the
// source vectors are held stable from start until done.
module vec_exec_unit
    import vec_pkg::*;
#(
    parameter int N     = 8,
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(N + 1),
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       opcode,
    input  logic [CNT_W-1:0] vlen,
    input  logic [N*W-1:0]   a_vec,
    input  logic [N*W-1:0]   b_vec,
    input  logic             mask_load,
    input  logic [N-1:0]     mask_wdata,
    output logic             busy,
    output logic             done,
    output logic [N*W-1:0]   dst_vec,
    output logic [N-1:0]     mask_vec
);
    vop_e             op_q;
    logic             issue_valid, issue_last;
    logic [IDX_W-1:0] issue_idx;
    logic             wb_valid, wb_last;
    logic [IDX_W-1:0] wb_idx;
    logic [W-1:0]     wb_res;

    vec_issue_ctrl #(.N(N), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op_in       (vop_e'(opcode)),
        .vlen_in     (vlen),
        .wb_last     (wb_valid && wb_last),
        .busy        (busy),
        .done        (done),
        .op_q        (op_q),
        .issue_valid (issue_valid),
        .issue_idx   (issue_idx),
        .issue_last  (issue_last)
    );

    vec_lane_pipe #(.N(N), .W(W), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_q),
        .in_valid (issue_valid),
        .in_idx   (issue_idx),
        .in_last  (issue_last),
        .a_vec    (a_vec),
        .b_vec    (b_vec),
        .wb_valid (wb_valid),
        .wb_idx   (wb_idx),
        .wb_last  (wb_last),
        .wb_res   (wb_res)
    );

    vec_wb_regs #(.N(N), .W(W), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .is_test    (op_q == OP_TSTZ),
        .wb_valid   (wb_valid),
        .wb_idx     (wb_idx),
        .wb_res     (wb_res),
        .mask_load  (mask_load),
        .mask_wdata (mask_wdata),
        .dst_vec    (dst_vec),
        .mask_vec   (mask_vec)
    );

    // R4
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (vlen == '0) |=> done && !busy);
    // R2
    done_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/vec_exec_unit_bench.sv
// Self-checking bench: seeded random instructions plus directed corners.
module vec_exec_unit_bench;
    localparam int N = 8;
    localparam int W = 16;
    localparam int DEPTH = 4;
    localparam int CNT_W = $clog2(N + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       opcode = '0;
    logic [CNT_W-1:0] vlen = '0;
    logic [N*W-1:0]   a_vec = '0;
    logic [N*W-1:0]   b_vec = '0;
    logic             mask_load = 1'b0;
    logic [N-1:0]     mask_wdata = '0;
    logic             busy, done;
    logic [N*W-1:0]   dst_vec;
    logic [N-1:0]     mask_vec;

    int checks = 0;
    int fails = 0;
    logic [N*W-1:0] exp_dst = '0;
    logic [N-1:0]   exp_mask = '1;

    always #2.5 clk = ~clk;

    vec_exec_unit #(.N(N), .W(W), .DEPTH(DEPTH)) u_vec_exec_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .vlen(vlen),
        .a_vec(a_vec), .b_vec(b_vec), .mask_load(mask_load),
        .mask_wdata(mask_wdata), .busy(busy), .done(done),
        .dst_vec(dst_vec), .mask_vec(mask_vec)
    );

    function automatic logic [W-1:0] elem_ref(input logic [1:0] op,
                                              input logic [W-1:0] a,
                                              input logic [W-1:0] b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            default: return a >> 1;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [1:0] op, input int len);
        int l = (len > N) ? N : len;
        for (int i = 0; i < l; i++) begin
            if (op == 2'd3) exp_mask[i] = (a_vec[i*W +: W] == '0);
            else if (exp_mask[i])
                exp_dst[i*W +: W] = elem_ref(op, a_vec[i*W +: W], b_vec[i*W +: W]);
        end
    endtask

    task automatic load_mask(input logic [N-1:0] m);
        mask_load = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_load = 1'b0;
        exp_mask = m;
        check("R9", "mask after load", N*W'(mask_vec), N*W'(m));
    endtask

    // Run one instruction; disturb injects start/mask_load while busy (R8).
    task automatic run_op(input logic [1:0] op, input int len, input bit disturb,
                          input string req);
        int cycles;
        int l = (len > N) ? N : len;
        opcode = op; vlen = CNT_W'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        while (!done && cycles < 64) begin
            if (disturb && cycles == 2) begin
                start = 1'b1; opcode = ~op; vlen = CNT_W'(N);
                mask_load = 1'b1; mask_wdata = ~exp_mask;
            end
            @(negedge clk);
            start = 1'b0; mask_load = 1'b0;
            cycles++;
        end
        model(op, len);
        check("R2", "done latency", N*W'(cycles),
              N*W'((l == 0) ? 1 : l + DEPTH + 1));
        check(req, "dst_vec", dst_vec, exp_dst);
        check(req, "mask_vec", N*W'(mask_vec), N*W'(exp_mask));
        check("R2", "busy low at done", N*W'(busy), '0);
        @(negedge clk);
        check("R2", "done single pulse", N*W'(done), '0);
    endtask

    task automatic rand_srcs(input int zero_pct);
        for (int i = 0; i < N; i++) begin
            a_vec[i*W +: W] = ($urandom_range(0, 99) < zero_pct) ? '0 : W'($urandom);
            b_vec[i*W +: W] = W'($urandom);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(5 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20211125));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "dst after reset", dst_vec, '0);
        check("R1", "mask after reset", N*W'(mask_vec), N*W'({N{1'b1}}));
        check("R1", "busy/done after reset", N*W'({busy, done}), '0);

        // R5 add with full mask, full length
        rand_srcs(0);
        run_op(2'd0, N, 1'b0, "R5");
        // R5 subtract wraps
        for (int i = 0; i < N; i++) begin
            a_vec[i*W +: W] = W'(i); b_vec[i*W +: W] = W'(i + 1);
        end
        run_op(2'd1, N, 1'b0, "R5");
        // R5 halve of all-ones is logical
        a_vec = '1;
        run_op(2'd2, N, 1'b0, "R5");
        // R6 partial mask predication
        load_mask(8'b1010_0110);
        rand_srcs(0);
        run_op(2'd0, N, 1'b0, "R6");
        // R6 all masked: nothing written
        load_mask('0);
        rand_srcs(0);
        run_op(2'd1, N, 1'b0, "R6");
        // R3 short length leaves upper elements
        load_mask('1);
        rand_srcs(0);
        run_op(2'd0, 3, 1'b0, "R3");
        // R3 length above N clamps
        rand_srcs(0);
        run_op(2'd1, 12, 1'b0, "R3");
        // R4 zero length
        rand_srcs(0);
        run_op(2'd0, 0, 1'b0, "R4");
        // R7 test partial length, then arithmetic predicated by it
        load_mask(8'b0101_0101);
        rand_srcs(50);
        run_op(2'd3, 5, 1'b0, "R7");
        b_vec = '1;
        run_op(2'd0, N, 1'b0, "R7");
        // R8 disturbed instructions
        rand_srcs(30);
        run_op(2'd0, 6, 1'b1, "R8");
        run_op(2'd3, N, 1'b1, "R8");

        // Random mix
        for (int t = 0; t < 40; t++) begin
            if ($urandom_range(0, 3) == 0) load_mask(N'($urandom));
            rand_srcs(25);
            run_op(2'($urandom_range(0, 3)), $urandom_range(0, 10),
                   1'($urandom_range(0, 3) == 0), "R5");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule